// File: doc/BRIEF.md
# Channel Assignment Repair and Utility Unit

This unit takes a candidate solution for a spectrum-sharing search and makes it legal, then scores it. A candidate is a bit matrix with one row per user and one bit per channel, where a 1 means the channel is granted to that user. The unit first removes every grant that the user is not allowed to use. It then walks each channel and settles interference conflicts, so that no two users who conflict on that channel both keep it. Finally it adds up a per-user, per-channel reward over every grant that remains. A larger sum means a better solution.

The problem tables sit in registers or RAM next to the unit and are read through combinational read ports. The unit drives a read address and uses the returned data in the same cycle. There are three tables: the availability rows, the conflict lists for each channel and user, and the reward rows. A candidate and the active user and channel counts are accepted through a valid/ready handshake. The repaired matrix and its utility are offered through a second valid/ready handshake. The unit works on one candidate at a time. Repair and scoring take MAX_USERS + users×channels + MAX_USERS cycles.

Top module: `chanfix_unit`

## Requirements
- R1: After reset `inReady` is 1, `outValid` is 0 and `outUtil` is 0.
- R2: A candidate is accepted only in a cycle where `inValid` and `inReady` are both 1, and `inReady` is 1 only while no candidate is in progress. `inValid` and `candIn` given while a candidate is in progress have no effect on its result.
- R3: A result bit for user u and channel m may be 1 only if bit m of the availability row for user u is 1. The candidate bit is cleared otherwise.
- R4: Conflicts are settled for each channel in ascending user order. A user loses channel m if it still holds the channel after R3 and an earlier user that kept channel m is listed as conflicting. User u is listed as conflicting when bit k of the conflict word read for (channel m, user u) is 1, where k is the earlier user. Bits for users equal to or above u are not consulted. Conflict repair only clears bits.
- R5: `outUtil` equals the sum, over every result bit that is 1, of the reward for that user and channel. The reward for channel m is the unsigned byte at bits [8m+7:8m] of the reward row for that user.
- R6: The counts `cfgUsers` and `cfgChans` are sampled at acceptance, and a value above the maximum is treated as the maximum. Rows of users at or above the user count, and columns of channels at or above the channel count, are 0 in the result and add nothing. A count of 0 gives an all-zero result.
- R7: `outValid` stays 1, and `outMatrix` and `outUtil` stay unchanged, until `outReady` is seen. The unit then returns to idle with `inReady` at 1.
- R8: The utility is 18 bits wide and does not overflow. With 32 users and 32 channels all granted, all available, no conflicts and every reward at 255, it reads 261120.
- R9: In `outMatrix` and `candIn`, the bit for user u and channel m is at index u×MAX_CHANS + m.

Requirements R3 to R9 apply to every accepted candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Candidate offered |
| inReady | output | 1 | Unit idle and able to accept |
| candIn | input | MAX_USERS*MAX_CHANS | Candidate matrix, bit u*MAX_CHANS+m |
| cfgUsers | input | $clog2(MAX_USERS+1) | Active user count |
| cfgChans | input | $clog2(MAX_CHANS+1) | Active channel count |
| availAddr | output | $clog2(MAX_USERS) | User whose availability row is read |
| availData | input | MAX_CHANS | Availability row, bit m = channel m allowed |
| confChan | output | $clog2(MAX_CHANS) | Channel of the conflict word read |
| confUser | output | $clog2(MAX_USERS) | User of the conflict word read |
| confData | input | MAX_USERS | Bit k = user k conflicts with confUser on confChan |
| rwdAddr | output | $clog2(MAX_USERS) | User whose reward row is read |
| rwdData | input | MAX_CHANS*RWD_W | Reward row, byte m = reward of channel m |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Result taken |
| outMatrix | output | MAX_USERS*MAX_CHANS | Repaired matrix |
| outUtil | output | UTIL_W | Utility of the repaired matrix |

## Verification
The bench tries the repair with random candidates, dense random availability, sparse symmetric conflicts and random counts. This mix exercises masking, conflict ordering and summation together. A directed chain is then run: three users on one channel, where user 0 conflicts with user 1 and user 1 conflicts with user 2. It separates correct ordering, in which user 2 keeps the channel because user 1 already lost it, from a design that compares against the raw candidate. Three more directed cases cover the bounds of the counts and of the sum: a fully granted maximum-reward matrix, a count of zero, and an all-blocked availability table. A candidate offered while the unit is busy shows whether that stimulus leaks into the result in progress.

// File: rtl/chanfix_pkg.sv
package chanfix_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AVAIL,
    PH_CONFL,
    PH_SUM,
    PH_DONE
  } phase_e;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic load;       // capture candidate, clear accumulator
    logic availStep;  // mask one row with availability and counts
    logic confStep;   // settle one (channel, user) conflict cell
    logic sumStep;    // add one row's rewards
  } stepCtl_t;

endpackage

// File: rtl/chanfix_ctrl.sv
module chanfix_ctrl
  import chanfix_pkg::*;
#(
  parameter int MAX_USERS = 32,
  parameter int MAX_CHANS = 32,
  localparam int UIDX_W = (MAX_USERS > 1) ? $clog2(MAX_USERS) : 1,
  localparam int CIDX_W = (MAX_CHANS > 1) ? $clog2(MAX_CHANS) : 1,
  localparam int UCNT_W = $clog2(MAX_USERS + 1),
  localparam int CCNT_W = $clog2(MAX_CHANS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              outReady,
  output logic              outValid,
  input  logic [UCNT_W-1:0] cfgUsers,
  input  logic [CCNT_W-1:0] cfgChans,
  output stepCtl_t          step,
  output logic [UIDX_W-1:0] userIdx,
  output logic [CIDX_W-1:0] chanIdx,
  output logic [UCNT_W-1:0] userCnt,
  output logic [CCNT_W-1:0] chanCnt
);

  phase_e            stateQ;
  logic [UIDX_W-1:0] uQ;
  logic [CIDX_W-1:0] mQ;
  logic [UCNT_W-1:0] usersQ;
  logic [CCNT_W-1:0] chansQ;

  logic              lastRow;
  logic              lastActUser;
  logic              lastActChan;
  logic [UCNT_W-1:0] clampUsers;
  logic [CCNT_W-1:0] clampChans;

  assign lastRow     = (uQ == UIDX_W'(MAX_USERS - 1));
  assign lastActUser = ((UCNT_W'(uQ) + UCNT_W'(1)) == usersQ);
  assign lastActChan = ((CCNT_W'(mQ) + CCNT_W'(1)) == chansQ);
  assign clampUsers  = (cfgUsers > UCNT_W'(MAX_USERS)) ? UCNT_W'(MAX_USERS) : cfgUsers;
  assign clampChans  = (cfgChans > CCNT_W'(MAX_CHANS)) ? CCNT_W'(MAX_CHANS) : cfgChans;

  assign inReady  = (stateQ == PH_IDLE);
  assign outValid = (stateQ == PH_DONE);
  assign userIdx  = uQ;
  assign chanIdx  = mQ;
  assign userCnt  = usersQ;
  assign chanCnt  = chansQ;

  always_comb begin
    step           = '0;
    step.load      = (stateQ == PH_IDLE) && inValid;
    step.availStep = (stateQ == PH_AVAIL);
    step.confStep  = (stateQ == PH_CONFL);
    step.sumStep   = (stateQ == PH_SUM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PH_IDLE;
      uQ     <= '0;
      mQ     <= '0;
      usersQ <= '0;
      chansQ <= '0;
    end else begin
      unique case (stateQ)
        PH_IDLE: begin
          if (inValid) begin
            usersQ <= clampUsers;
            chansQ <= clampChans;
            uQ     <= '0;
            mQ     <= '0;
            stateQ <= PH_AVAIL;
          end
        end
        PH_AVAIL: begin
          if (lastRow) begin
            uQ     <= '0;
            mQ     <= '0;
            stateQ <= ((usersQ != '0) && (chansQ != '0)) ? PH_CONFL : PH_SUM;
          end else begin
            uQ <= uQ + UIDX_W'(1);
          end
        end
        PH_CONFL: begin
          if (lastActUser) begin
            uQ <= '0;
            if (lastActChan) begin
              stateQ <= PH_SUM;
            end else begin
              mQ <= mQ + CIDX_W'(1);
            end
          end else begin
            uQ <= uQ + UIDX_W'(1);
          end
        end
        PH_SUM: begin
          if (lastRow) begin
            uQ     <= '0;
            stateQ <= PH_DONE;
          end else begin
            uQ <= uQ + UIDX_W'(1);
          end
        end
        PH_DONE: begin
          if (outReady) stateQ <= PH_IDLE;
        end
        default: stateQ <= PH_IDLE;
      endcase
    end
  end

  // R2
  accept_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R2
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !outValid) |=> !$past(step.load));

  // R7
  result_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R7
  release_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (inReady && !outValid));

endmodule

// File: rtl/chanfix_datapath.sv
module chanfix_datapath
  import chanfix_pkg::*;
#(
  parameter int MAX_USERS = 32,
  parameter int MAX_CHANS = 32,
  parameter int RWD_W     = 8,
  parameter int UTIL_W    = 18,
  localparam int UIDX_W = (MAX_USERS > 1) ? $clog2(MAX_USERS) : 1,
  localparam int CIDX_W = (MAX_CHANS > 1) ? $clog2(MAX_CHANS) : 1,
  localparam int UCNT_W = $clog2(MAX_USERS + 1),
  localparam int CCNT_W = $clog2(MAX_CHANS + 1),
  localparam int MAT_W  = MAX_USERS * MAX_CHANS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  stepCtl_t                   step,
  input  logic [UIDX_W-1:0]          userIdx,
  input  logic [CIDX_W-1:0]          chanIdx,
  input  logic [UCNT_W-1:0]          userCnt,
  input  logic [CCNT_W-1:0]          chanCnt,
  input  logic [MAT_W-1:0]           candIn,
  input  logic [MAX_CHANS-1:0]       availData,
  input  logic [MAX_USERS-1:0]       confData,
  input  logic [MAX_CHANS*RWD_W-1:0] rwdData,
  output logic [MAT_W-1:0]           matrixOut,
  output logic [UTIL_W-1:0]          utilOut
);

  logic [MAX_CHANS-1:0] rowQ [MAX_USERS];
  logic [MAX_USERS-1:0] holdQ;
  logic [UTIL_W-1:0]    accQ;

  logic [MAX_CHANS-1:0] chanMask;
  logic [MAX_USERS-1:0] earlier;
  logic [MAX_USERS-1:0] nextHold;
  logic [MAX_CHANS-1:0] curRow;
  logic                 curBit;
  logic                 userActive;
  logic                 loses;
  logic [UTIL_W-1:0]    rowSum;

  always_comb begin
    for (int m = 0; m < MAX_CHANS; m++) begin
      chanMask[m] = (CCNT_W'(m) < chanCnt);
    end
    for (int k = 0; k < MAX_USERS; k++) begin
      earlier[k] = (UIDX_W'(k) < userIdx);
    end
  end

  assign curRow     = rowQ[userIdx];
  assign curBit     = curRow[chanIdx];
  assign userActive = (UCNT_W'(userIdx) < userCnt);
  assign loses      = curBit && |(confData & holdQ & earlier);

  // Holders of the current channel among users already visited
  always_comb begin
    nextHold          = (userIdx == '0) ? '0 : holdQ;
    nextHold[userIdx] = curBit && !loses;
  end

  always_comb begin
    rowSum = '0;
    for (int m = 0; m < MAX_CHANS; m++) begin
      if (curRow[m]) rowSum = rowSum + UTIL_W'(rwdData[m*RWD_W +: RWD_W]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < MAX_USERS; u++) rowQ[u] <= '0;
      holdQ <= '0;
      accQ  <= '0;
    end else begin
      if (step.load) begin
        for (int u = 0; u < MAX_USERS; u++) begin
          rowQ[u] <= candIn[u*MAX_CHANS +: MAX_CHANS];
        end
        holdQ <= '0;
        accQ  <= '0;
      end
      if (step.availStep) begin
        rowQ[userIdx] <= userActive ? (curRow & availData & chanMask) : '0;
      end
      if (step.confStep) begin
        if (loses) rowQ[userIdx][chanIdx] <= 1'b0;
        holdQ <= nextHold;
      end
      if (step.sumStep) begin
        accQ <= accQ + rowSum;
      end
    end
  end

  for (genvar u = 0; u < MAX_USERS; u++) begin : g_flat
    assign matrixOut[u*MAX_CHANS +: MAX_CHANS] = rowQ[u];
  end
  assign utilOut = accQ;

  // R3
  avail_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    step.availStep |=> ((rowQ[$past(userIdx)] & ~$past(availData)) == '0));

  // R6
  idle_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step.availStep && !userActive) |=> (rowQ[$past(userIdx)] == '0));

  // R6
  idle_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    step.availStep |=> ((rowQ[$past(userIdx)] & ~$past(chanMask)) == '0));

  // R4
  repair_clears_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    step.confStep |=> ((rowQ[$past(userIdx)] & ~$past(curRow)) == '0));

  // R5
  acc_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    step.sumStep |=> (accQ >= $past(accQ)));

endmodule

// File: rtl/chanfix_unit.sv
module chanfix_unit
  import chanfix_pkg::*;
#(
  parameter int MAX_USERS = 32,
  parameter int MAX_CHANS = 32,
  parameter int RWD_W     = 8,
  parameter int UTIL_W    = 18,
  localparam int UIDX_W = (MAX_USERS > 1) ? $clog2(MAX_USERS) : 1,
  localparam int CIDX_W = (MAX_CHANS > 1) ? $clog2(MAX_CHANS) : 1,
  localparam int UCNT_W = $clog2(MAX_USERS + 1),
  localparam int CCNT_W = $clog2(MAX_CHANS + 1),
  localparam int MAT_W  = MAX_USERS * MAX_CHANS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [MAT_W-1:0]           candIn,
  input  logic [UCNT_W-1:0]          cfgUsers,
  input  logic [CCNT_W-1:0]          cfgChans,
  output logic [UIDX_W-1:0]          availAddr,
  input  logic [MAX_CHANS-1:0]       availData,
  output logic [CIDX_W-1:0]          confChan,
  output logic [UIDX_W-1:0]          confUser,
  input  logic [MAX_USERS-1:0]       confData,
  output logic [UIDX_W-1:0]          rwdAddr,
  input  logic [MAX_CHANS*RWD_W-1:0] rwdData,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [MAT_W-1:0]           outMatrix,
  output logic [UTIL_W-1:0]          outUtil
);

  stepCtl_t          step;
  logic [UIDX_W-1:0] userIdx;
  logic [CIDX_W-1:0] chanIdx;
  logic [UCNT_W-1:0] userCnt;
  logic [CCNT_W-1:0] chanCnt;

  chanfix_ctrl #(
    .MAX_USERS(MAX_USERS),
    .MAX_CHANS(MAX_CHANS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .cfgUsers (cfgUsers),
    .cfgChans (cfgChans),
    .step     (step),
    .userIdx  (userIdx),
    .chanIdx  (chanIdx),
    .userCnt  (userCnt),
    .chanCnt  (chanCnt)
  );

  chanfix_datapath #(
    .MAX_USERS(MAX_USERS),
    .MAX_CHANS(MAX_CHANS),
    .RWD_W    (RWD_W),
    .UTIL_W   (UTIL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .step      (step),
    .userIdx   (userIdx),
    .chanIdx   (chanIdx),
    .userCnt   (userCnt),
    .chanCnt   (chanCnt),
    .candIn    (candIn),
    .availData (availData),
    .confData  (confData),
    .rwdData   (rwdData),
    .matrixOut (outMatrix),
    .utilOut   (outUtil)
  );

  assign availAddr = userIdx;
  assign confChan  = chanIdx;
  assign confUser  = userIdx;
  assign rwdAddr   = userIdx;

  // R7
  result_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outUtil) && $stable(outMatrix)));

endmodule

// File: tb/sim_chanfix_unit.sv
module sim_chanfix_unit;

  localparam int NU = 32;
  localparam int NC = 32;
  localparam int MW = NU * NC;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic            inReady;
  logic [MW-1:0]   candIn = '0;
  logic [5:0]      cfgUsers = '0;
  logic [5:0]      cfgChans = '0;
  logic [4:0]      availAddr;
  logic [NC-1:0]   availData;
  logic [4:0]      confChan;
  logic [4:0]      confUser;
  logic [NU-1:0]   confData;
  logic [4:0]      rwdAddr;
  logic [NC*8-1:0] rwdData;
  logic            outValid;
  logic            outReady = 1'b0;
  logic [MW-1:0]   outMatrix;
  logic [17:0]     outUtil;

  logic [NC-1:0] availM [NU];
  logic [NU-1:0] confM  [NC][NU];
  logic [7:0]    rwdM   [NU][NC];

  logic [MW-1:0] expFlat;
  int            expUtil;
  int            nChecks = 0;
  int            nFails = 0;
  int            cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign availData = availM[availAddr];
  assign confData  = confM[confChan][confUser];
  always_comb begin
    for (int m = 0; m < NC; m++) rwdData[m*8 +: 8] = rwdM[rwdAddr][m];
  end

  chanfix_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .candIn(candIn), .cfgUsers(cfgUsers), .cfgChans(cfgChans),
    .availAddr(availAddr), .availData(availData),
    .confChan(confChan), .confUser(confUser), .confData(confData),
    .rwdAddr(rwdAddr), .rwdData(rwdData),
    .outValid(outValid), .outReady(outReady),
    .outMatrix(outMatrix), .outUtil(outUtil)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL R7 watchdog: cycles %0d expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chkVal(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkMat(input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s matrix: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic refCalc(input logic [MW-1:0] cand, input int users, input int chans);
    logic [NC-1:0] r [NU];
    logic [NU-1:0] hold;
    int uc, cc;
    uc = (users > NU) ? NU : users;
    cc = (chans > NC) ? NC : chans;
    for (int u = 0; u < NU; u++) begin
      r[u] = cand[u*NC +: NC] & availM[u];
      for (int m = 0; m < NC; m++) if (m >= cc || u >= uc) r[u][m] = 1'b0;
    end
    for (int m = 0; m < cc; m++) begin
      hold = '0;
      for (int u = 0; u < uc; u++) begin
        if (r[u][m]) begin
          if ((confM[m][u] & hold & ((NU'(1) << u) - NU'(1))) != '0) r[u][m] = 1'b0;
          else hold[u] = 1'b1;
        end
      end
    end
    expUtil = 0;
    for (int u = 0; u < NU; u++) begin
      expFlat[u*NC +: NC] = r[u];
      for (int m = 0; m < NC; m++) if (r[u][m]) expUtil += rwdM[u][m];
    end
  endtask

  task automatic fillTables(input bit allAvail, input bit noAvail, input bit noConf, input int rwdFix);
    for (int u = 0; u < NU; u++) begin
      availM[u] = allAvail ? '1 : noAvail ? '0 : ($urandom | $urandom);
      for (int m = 0; m < NC; m++) begin
        rwdM[u][m] = (rwdFix >= 0) ? 8'(rwdFix) : 8'($urandom);
        confM[m][u] = '0;
      end
    end
    if (!noConf) begin
      for (int m = 0; m < NC; m++)
        for (int u = 0; u < NU; u++)
          for (int k = u + 1; k < NU; k++)
            if (($urandom % 6) == 0) begin
              confM[m][u][k] = 1'b1;
              confM[m][k][u] = 1'b1;
            end
    end
  endtask

  function automatic logic [MW-1:0] randCand();
    logic [MW-1:0] c;
    for (int w = 0; w < MW / 32; w++) c[w*32 +: 32] = $urandom | $urandom;
    return c;
  endfunction

  task automatic runCase(input logic [MW-1:0] cand, input int users, input int chans,
                         input string req, input bit pokeBusy);
    int waitCnt;
    logic [17:0] heldUtil;
    refCalc(cand, users, chans);
    @(negedge clk);
    candIn   = cand;
    cfgUsers = 6'(users);
    cfgChans = 6'(chans);
    inValid  = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    if (pokeBusy) begin
      candIn   = ~cand;
      cfgUsers = 6'd5;
      inValid  = 1'b1;
      chkVal("R2", "inReady while busy", inReady, 0);
      repeat (3) @(negedge clk);
      inValid = 1'b0;
    end
    waitCnt = 0;
    while (!outValid && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    chkVal(req, "outValid reached", outValid, 1);
    chkMat(req, outMatrix, expFlat);
    chkVal(req, "utility", outUtil, expUtil);
    heldUtil = outUtil;
    @(negedge clk);
    chkVal("R7", "valid held", outValid, 1);
    chkVal("R7", "utility held", outUtil, heldUtil);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chkVal("R7", "idle after take", {outValid, inReady}, 2'b01);
  endtask

  initial begin
    logic [MW-1:0] c;
    void'($urandom(32'd2024));
    fillTables(1'b0, 1'b0, 1'b0, -1);
    repeat (3) @(negedge clk);
    // R1 reset state
    chkVal("R1", "inReady", inReady, 1);
    chkVal("R1", "outValid", outValid, 0);
    chkVal("R1", "utility", outUtil, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8 full matrix, maximum rewards
    fillTables(1'b1, 1'b0, 1'b1, 255);
    runCase('1, 32, 32, "R8", 1'b0);
    chkVal("R8", "max utility constant", outUtil, 261120);
    chkVal("R9", "last bit index", outMatrix[MW-1], 1);

    // R3 nothing available
    fillTables(1'b0, 1'b1, 1'b1, -1);
    runCase(randCand(), 32, 32, "R3", 1'b0);
    chkVal("R3", "all blocked utility", outUtil, 0);

    // R4 chain on channel 0: 0-1 and 1-2 conflict
    fillTables(1'b1, 1'b0, 1'b1, -1);
    confM[0][0][1] = 1'b1; confM[0][1][0] = 1'b1;
    confM[0][1][2] = 1'b1; confM[0][2][1] = 1'b1;
    c = '0;
    c[0] = 1'b1; c[NC] = 1'b1; c[2*NC] = 1'b1;
    runCase(c, 3, 1, "R4", 1'b0);
    chkVal("R4", "chain user0", outMatrix[0], 1);
    chkVal("R4", "chain user1", outMatrix[NC], 0);
    chkVal("R4", "chain user2", outMatrix[2*NC], 1);
    chkVal("R5", "chain utility", outUtil, rwdM[0][0] + rwdM[2][0]);

    // R6 zero counts, partial counts, oversize counts
    runCase('1, 0, 32, "R6", 1'b0);
    chkVal("R6", "zero users utility", outUtil, 0);
    runCase('1, 7, 9, "R6", 1'b0);
    runCase('1, 40, 63, "R6", 1'b0);

    // R2 busy stimulus ignored
    fillTables(1'b0, 1'b0, 1'b0, -1);
    runCase(randCand(), 20, 24, "R2", 1'b1);

    // Random runs: R3 R4 R5 R6
    for (int t = 0; t < 30; t++) begin
      if (t % 5 == 0) fillTables(1'b0, 1'b0, 1'b0, -1);
      runCase(randCand(), 1 + ($urandom % 32), 1 + ($urandom % 32), "R5", 1'b0);
    end

    summary();
    $finish;
  end

endmodule